// File: doc/BRIEF.md
# Link Residency Time Analyzer

This block measures how long a serial link spends in one chosen condition, or how many payload bytes of one chosen category pass, over a measurement window. Software picks a report item and a window length in one control register, then sets a run bit. While the window is open, a 64-bit result adds the amount contributed by the chosen item on every clock. The item is either a single-bit condition flag or a per-cycle payload byte count. The window is either a fixed number of microsecond ticks, after which the run bit drops by itself, or a manual window that stays open until software clears the run bit.

The result is read as two 32-bit words. Reading the upper word captures the lower word at the same instant, so the pair stays coherent while counting continues. Link state tracking lies outside the block. It only sees the per-cycle flags, the payload byte counts and a one-cycle microsecond tick.

Top module: `link_residency_analyzer`

## Requirements
- R1: After reset the control word, the upper result word and the lower result word all read as zero.
- R2: The control word at offset 0x10 holds the report selector in bits 31:24, the window code in bits 15:8 and the run bit in bit 0. All other bits read back as zero.
- R3: A control write that takes the run bit from 0 to 1 clears the result. On every clock edge that closes a cycle with the run bit set, the result grows by the amount of the selected item.
- R4: Report codes select these amounts: 0x00 is one on every cycle, 0x01 is flag bit 0 (transmit L0s), 0x02 is flag bit 1 (receive L0s), 0x03 is bit 2 (L0), 0x04 is bit 3 (L1), 0x05 is bit 4 (L1.1), 0x06 is bit 5 (L1.2), 0x07 is bit 6 (recovery or configuration), 0x08 is bit 0 AND bit 1, and 0x09 is bit 7 (L1 auxiliary).
- R5: Report codes 0x20 to 0x23 add the payload byte count of lane 0 to 3. Lane i occupies bits 8i+7:8i of the payload input.
- R6: Any report code not listed in R4 or R5 adds nothing.
- R7: Window codes 0xFF, 0x01, 0x02, 0x03, 0x04, 0x05 and 0x06 close the window after 4, 1000, 10000, 100000, 1000000, 2000000 and 4000000 microsecond ticks. Only tick-high cycles count. At that point the run bit clears itself and the result then holds still.
- R8: Window code 0x00 and every code not listed in R7 give a manual window, which stays open until software writes the run bit to 0, whatever the tick does.
- R9: A read of the upper word at 0x18 captures the lower 32 result bits. A read of the lower word at 0x14 returns the captured value, not the live one.
- R10: A control write with the run bit set that lands on the cycle a timed window expires starts a fresh window: the result clears and the tick count restarts.
- R11: Writing the run bit as 1 while a window is already open neither clears the result nor restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| link_flags | input | 8 | Per-cycle condition flags, bit map in R4 |
| payload_bytes | input | 32 | Four per-cycle payload byte counts, lane map in R5 |

## Verification
Two functions can fall on the same clock edge: a timed window expiring and a software control write. The bench starts a 4-tick window with ticks every cycle. It then times a second run-bit write so that its edge lands on the expiry edge. The write must win and restart the window. A final result of exactly four cycles with the run bit clear shows that the clear and the tick restart both took effect. A higher count or a run bit still set would expose a lost restart.

// File: rtl/lra_pkg.sv
package lra_pkg;
  localparam int AW    = 8;
  localparam int DW    = 32;
  localparam int RW    = 64;
  localparam int TW    = 23;
  localparam int NFLAG = 8;
  localparam int NPAY  = 4;

  localparam logic [AW-1:0] OFS_CTL = 8'h10;
  localparam logic [AW-1:0] OFS_LO  = 8'h14;
  localparam logic [AW-1:0] OFS_HI  = 8'h18;

  localparam int FL_TXL0S = 0;
  localparam int FL_RXL0S = 1;
  localparam int FL_L0    = 2;
  localparam int FL_L1    = 3;
  localparam int FL_L11   = 4;
  localparam int FL_L12   = 5;
  localparam int FL_RECOV = 6;
  localparam int FL_AUX   = 7;

  // window code to tick count; zero means manual window
  function automatic logic [TW-1:0] win_ticks(input logic [7:0] code);
    case (code)
      8'hFF:   win_ticks = TW'(4);
      8'h01:   win_ticks = TW'(1000);
      8'h02:   win_ticks = TW'(10000);
      8'h03:   win_ticks = TW'(100000);
      8'h04:   win_ticks = TW'(1000000);
      8'h05:   win_ticks = TW'(2000000);
      8'h06:   win_ticks = TW'(4000000);
      default: win_ticks = '0;
    endcase
  endfunction
endpackage

// File: rtl/lra_item_select.sv
module lra_item_select
  import lra_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic [7:0]         sel,
  input  logic [NFLAG-1:0]   flags,
  input  logic [NPAY*PW-1:0] payload,
  output logic [PW-1:0]      amount
);
  logic [PW-1:0] lane [NPAY];

  for (genvar g = 0; g < NPAY; g++) begin : g_lane
    assign lane[g] = payload[g*PW +: PW];
  end

  always_comb begin
    amount = '0;
    case (sel)
      8'h00: amount = PW'(1);
      8'h01: amount = PW'(flags[FL_TXL0S]);
      8'h02: amount = PW'(flags[FL_RXL0S]);
      8'h03: amount = PW'(flags[FL_L0]);
      8'h04: amount = PW'(flags[FL_L1]);
      8'h05: amount = PW'(flags[FL_L11]);
      8'h06: amount = PW'(flags[FL_L12]);
      8'h07: amount = PW'(flags[FL_RECOV]);
      8'h08: amount = PW'(flags[FL_TXL0S] & flags[FL_RXL0S]);
      8'h09: amount = PW'(flags[FL_AUX]);
      default: begin
        if (sel[7:2] == 6'b001000) amount = lane[sel[1:0]];
      end
    endcase
  end
endmodule

// File: rtl/lra_window_timer.sv
module lra_window_timer
  import lra_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic       us_tick,
  input  logic [7:0] win_code,
  output logic       expire
);
  logic [TW-1:0] lim_q, lim_d, cnt_q, cnt_d;
  logic          timed, upd;

  always_comb begin
    timed  = (lim_q != '0);
    expire = run && timed && us_tick && (cnt_q == lim_q - TW'(1));
    upd    = start || (run && timed && us_tick);
    lim_d  = start ? win_ticks(win_code) : lim_q;
    cnt_d  = start ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      lim_q <= lim_d;
      cnt_q <= cnt_d;
    end
  end

  assert_tick_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((lim_q == '0) || (cnt_q < lim_q)));
endmodule

// File: rtl/link_residency_analyzer.sv
module link_residency_analyzer
  import lra_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic                 us_tick,
  input  logic [NFLAG-1:0]     link_flags,
  input  logic [NPAY*PW-1:0]   payload_bytes
);
  logic          rs_meta, rs_n;
  logic [7:0]    sel_q, win_q;
  logic          run_q, run_d;
  logic [RW-1:0] acc_q, acc_d;
  logic [DW-1:0] snap_q;
  logic          ctl_wr, hi_rd, start, expire, acc_en;
  logic [PW-1:0] amount;
  logic          unused_wbits;

  assign unused_wbits = ^{reg_wdata[23:16], reg_wdata[7:1]};

  // reset synchronizer: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  lra_item_select #(.PW(PW)) u_sel (
    .sel     (sel_q),
    .flags   (link_flags),
    .payload (payload_bytes),
    .amount  (amount)
  );

  lra_window_timer u_tmr (
    .clk      (clk),
    .rst_n    (rs_n),
    .start    (start),
    .run      (run_q),
    .us_tick  (us_tick),
    .win_code (reg_wdata[15:8]),
    .expire   (expire)
  );

  always_comb begin
    ctl_wr = reg_wr && (reg_addr == OFS_CTL);
    hi_rd  = reg_rd && (reg_addr == OFS_HI);
    start  = ctl_wr && reg_wdata[0] && (!run_q || expire);
    if (ctl_wr)      run_d = reg_wdata[0];
    else if (expire) run_d = 1'b0;
    else             run_d = run_q;
    acc_en = start || run_q;
    acc_d  = start ? '0 : acc_q + RW'(amount);
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      sel_q <= '0;
      win_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (ctl_wr) begin
        sel_q <= reg_wdata[31:24];
        win_q <= reg_wdata[15:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) snap_q <= '0;
    else if (hi_rd) snap_q <= acc_q[DW-1:0];
  end

  always_comb begin
    case (reg_addr)
      OFS_CTL: reg_rdata = {sel_q, 8'h00, win_q, 7'h00, run_q};
      OFS_LO:  reg_rdata = snap_q;
      OFS_HI:  reg_rdata = acc_q[RW-1:DW];
      default: reg_rdata = '0;
    endcase
  end

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rs_n)
    (reg_wr && (reg_addr == OFS_CTL) && reg_wdata[0] && !run_q) |=> (acc_q == '0));
  assert_grows_R3: assert property (@(posedge clk) disable iff (!rs_n)
    (run_q && !reg_wr) |=> (acc_q >= $past(acc_q)));
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rs_n)
    (!run_q && !reg_wr) |=> $stable(acc_q));
  assert_self_clear_R7: assert property (@(posedge clk) disable iff (!rs_n)
    (expire && !reg_wr) |=> !run_q);
  assert_snapshot_R9: assert property (@(posedge clk) disable iff (!rs_n)
    (reg_rd && (reg_addr == OFS_HI)) |=> (snap_q == $past(acc_q[DW-1:0])));
endmodule

// File: tb/sim_link_residency_analyzer.sv
module sim_link_residency_analyzer;
  logic        clk, rst_n, reg_wr, reg_rd, us_tick;
  logic [7:0]  reg_addr, link_flags;
  logic [31:0] reg_wdata, reg_rdata, payload_bytes;
  int          n_chk, n_fail;
  bit          done;

  link_residency_analyzer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .us_tick(us_tick), .link_flags(link_flags), .payload_bytes(payload_bytes)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_result(output logic [63:0] r);
    logic [31:0] hi, lo;
    rd(8'h18, hi);
    rd(8'h14, lo);
    r = {hi, lo};
  endtask

  // manual window: start edge at N0, stop edge at N(k+2)
  task automatic manual_run(input logic [7:0] sel, input int k);
    wr(8'h10, {sel, 16'h0000, 8'h01});
    repeat (k) @(negedge clk);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h10, d); check("R1 ctl", d, 0);
    rd(8'h18, d); check("R1 hi", d, 0);
    rd(8'h14, d); check("R1 lo", d, 0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(8'h10, 32'hAB5A_07FE);
    rd(8'h10, d); check("R2 layout", d, 32'hAB00_0700);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_manual;
    logic [63:0] r;
    manual_run(8'h00, 10);
    rd_result(r); check("R3 cycle count", r, 12);
    manual_run(8'h00, 3);
    rd_result(r); check("R3 cleared on start", r, 5);
  endtask

  task automatic t_flags;
    logic [63:0] r;
    link_flags = 8'h10;
    manual_run(8'h05, 3); rd_result(r); check("R4 L1.1", r, 5);
    manual_run(8'h02, 3); rd_result(r); check("R4 rx L0s off", r, 0);
    link_flags = 8'h01;
    manual_run(8'h08, 3); rd_result(r); check("R4 both L0s one side", r, 0);
    link_flags = 8'h03;
    manual_run(8'h08, 3); rd_result(r); check("R4 both L0s", r, 5);
    link_flags = 8'h80;
    manual_run(8'h09, 3); rd_result(r); check("R4 aux", r, 5);
  endtask

  task automatic t_payload;
    logic [63:0] r;
    payload_bytes = 32'h0909_0509;
    manual_run(8'h21, 3); rd_result(r); check("R5 lane1", r, 25);
    payload_bytes = 32'h0709_0909;
    manual_run(8'h23, 3); rd_result(r); check("R5 lane3", r, 35);
  endtask

  task automatic t_unlisted;
    logic [63:0] r;
    link_flags = 8'hFF; payload_bytes = 32'h0909_0909;
    manual_run(8'h30, 3); rd_result(r); check("R6 code 0x30", r, 0);
    manual_run(8'h0A, 3); rd_result(r); check("R6 code 0x0A", r, 0);
  endtask

  task automatic t_timed;
    logic [63:0] r;
    logic [31:0] d;
    link_flags = 8'h04;
    wr(8'h10, 32'h0000_FF01);
    repeat (10) @(negedge clk);
    rd(8'h10, d); check("R7 4us self clear", d[0], 0);
    rd_result(r); check("R7 4us count", r, 4);
    wr(8'h10, 32'h0300_0101);
    repeat (1100) @(negedge clk);
    rd(8'h10, d); check("R7 1ms self clear", d, 32'h0300_0100);
    rd_result(r); check("R7 1ms count", r, 1000);
    repeat (50) @(negedge clk);
    rd_result(r); check("R7 frozen", r, 1000);
    wr(8'h10, 32'h0300_0201);
    repeat (10100) @(negedge clk);
    rd_result(r); check("R7 10ms count", r, 10000);
    us_tick = 1'b0;
    wr(8'h10, 32'h0000_FF01);
    repeat (20) @(negedge clk);
    rd(8'h10, d); check("R7 no tick no expiry", d[0], 1);
    us_tick = 1'b1;
    repeat (10) @(negedge clk);
    rd(8'h10, d); check("R7 expiry after ticks", d[0], 0);
  endtask

  task automatic t_manual_codes;
    logic [31:0] d;
    logic [63:0] r;
    wr(8'h10, 32'h0000_0701);
    repeat (5) @(negedge clk);
    rd(8'h10, d); check("R8 undefined code open", d[0], 1);
    repeat (2) @(negedge clk);
    wr(8'h10, 32'h0);
    rd_result(r); check("R8 undefined code count", r, 11);
    wr(8'h10, 32'h0000_0001);
    repeat (30) @(negedge clk);
    rd(8'h10, d); check("R8 manual open", d[0], 1);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_snapshot;
    logic [31:0] d;
    logic [63:0] r;
    wr(8'h10, 32'h0000_0001);
    rd(8'h18, d); check("R9 hi", d, 0);
    rd(8'h14, d); check("R9 lo captured", d, 1);
    wr(8'h10, 32'h0);
    rd_result(r); check("R9 final", r, 6);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    logic [63:0] r;
    wr(8'h10, 32'h0000_FF01);
    repeat (2) @(negedge clk);
    wr(8'h10, 32'h0000_FF01);
    repeat (10) @(negedge clk);
    rd(8'h10, d); check("R10 closed", d[0], 0);
    rd_result(r); check("R10 restart count", r, 4);
  endtask

  task automatic t_rearm;
    logic [63:0] r;
    wr(8'h10, 32'h0000_0001);
    repeat (3) @(negedge clk);
    wr(8'h10, 32'h0000_0001);
    repeat (2) @(negedge clk);
    wr(8'h10, 32'h0);
    rd_result(r); check("R11 no restart", r, 9);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    us_tick = 1'b1; link_flags = '0; payload_bytes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fields();
    t_manual();
    t_flags();
    t_payload();
    t_unlisted();
    t_timed();
    t_manual_codes();
    t_snapshot();
    t_collide();
    t_rearm();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule